// File: doc/BRIEF.md
# Newline-Terminated Serial Packet Sender

This block collects a text packet from a host and sends it to a radio module over a one-wire asynchronous serial output. The host writes bytes through a valid/ready port into an internal buffer. It then pulses the end-of-packet input. The block sends the buffered bytes in the order they were written. It then appends a newline character (0x0A). The far end holds what it receives and only forwards it once the newline arrives, so the terminator is always sent, even for an empty packet.

Each packet is at most `MAX_PKT` bytes (default 256), and that count includes the terminator. This leaves room for `MAX_PKT-1` payload bytes. A write beyond that limit still completes its handshake, but the byte is dropped and a sticky overflow flag is raised. The bit period is `CLK_HZ/BAUD` clock cycles, truncated. The defaults are 100 MHz and 115,200 bit/s, which gives 868 cycles.

The sequencer has three states. `S_FILL` accepts writes and waits for end of packet. `S_NEXT` hands the serializer the next buffered byte, or the newline once the buffer is empty. `S_SHIFT` waits for that frame's stop bit to finish. The transitions are:
- FILL→NEXT on end of packet.
- NEXT→SHIFT always.
- SHIFT→NEXT when a payload frame finishes.
- SHIFT→FILL when the terminator frame finishes. This transition also clears the buffer.

Top module: `nl_pkt_tx`

## Requirements
- R1: After reset, `txd` is high, `busy` is low, `wr_ready` is high and `overflow` is low.
- R2: Each byte is sent as one low start bit, then 8 data bits least significant bit first, then a high stop bit. Each bit lasts `CLK_HZ/BAUD` cycles (truncated), and the line rests high whenever no frame is being sent.
- R3: After end of packet, the accepted bytes are sent in the order they were written, followed by one 0x0A byte.
- R4: End of packet with no bytes buffered sends a single 0x0A frame.
- R5: At most `MAX_PKT-1` payload bytes are accepted per packet. A further write with `wr_ready` high completes its handshake, is not sent, and sets `overflow`.
- R6: Once set, `overflow` stays high until reset.
- R7: While `busy` is high, `wr_ready` is low, and writes and end-of-packet pulses are ignored.
- R8: `busy` goes high in the cycle after end of packet is sampled. It goes low only after the stop bit of the 0x0A frame has been sent.
- R9: A write accepted in the same cycle as end of packet becomes the last payload byte of that packet.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | Host offers a byte |
| wr_data | input | 8 | Byte offered |
| wr_ready | output | 1 | Block accepts writes (idle and filling) |
| pkt_end | input | 1 | End of packet; starts transmission |
| txd | output | 1 | Serial output, idles high |
| busy | output | 1 | Packet transmission in progress |
| overflow | output | 1 | Sticky: a byte past the packet limit was dropped |

## Verification
A byte write and the end-of-packet request can land in the same cycle. This is provoked by raising `wr_valid` and `pkt_end` together on the third byte of a packet. The check is that the decoded line carries that byte last, directly before the newline. The same collision is also applied with the buffer already full. There the colliding byte must be dropped with `overflow` raised, while the 255 earlier bytes and the newline still go out. The bench also drives writes and end-of-packet pulses during transmission, and judges them by their absence from the decoded byte stream.

// File: rtl/nlt_pkg.sv
package nlt_pkg;
    typedef enum logic [1:0] {
        S_FILL,
        S_NEXT,
        S_SHIFT
    } tx_state_e;

    localparam logic [7:0] TERM_CHAR = 8'h0A;
endpackage

// File: rtl/nlt_baud.sv
module nlt_baud #(
    parameter int CPB = 868
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic tick
);
    localparam int CW = (CPB > 2) ? $clog2(CPB) : 1;
    localparam logic [CW-1:0] LAST = CW'(CPB - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n || !en) cnt <= '0;
        else if (cnt == LAST) cnt <= '0;
        else cnt <= cnt + 1'b1;
    end

    assign tick = en && (cnt == LAST);
endmodule

// File: rtl/nlt_ser.sv
module nlt_ser #(
    parameter int CPB = 868
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       load,
    input  logic [7:0] data,
    output logic       txd,
    output logic       active,
    output logic       done
);
    logic       tick;
    logic [3:0] bitn;
    logic [9:0] sh;

    nlt_baud #(.CPB(CPB)) u_baud (
        .clk  (clk),
        .rst_n(rst_n),
        .en   (active),
        .tick (tick)
    );

    assign done = active && tick && (bitn == 4'd9);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active <= 1'b0;
            bitn   <= '0;
            sh     <= '1;
        end else if (load) begin
            active <= 1'b1;
            bitn   <= '0;
            sh     <= {1'b1, data, 1'b0};
        end else if (done) begin
            active <= 1'b0;
            sh     <= '1;
        end else if (tick) begin
            bitn <= bitn + 1'b1;
            sh   <= {1'b1, sh[9:1]};
        end
    end

    assign txd = active ? sh[0] : 1'b1;

    // R2
    load_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> !active);
    // R2
    start_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> !txd);
endmodule

// File: rtl/nlt_buf.sv
module nlt_buf #(
    parameter int DEPTH = 256
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     clr,
    input  logic                     push,
    input  logic [7:0]               din,
    input  logic                     pop,
    output logic [7:0]               dout,
    output logic [$clog2(DEPTH)-1:0] level,
    output logic                     empty
);
    localparam int AW = $clog2(DEPTH);

    logic [7:0]    mem [DEPTH];
    logic [AW-1:0] wr_ptr;
    logic [AW-1:0] rd_ptr;

    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
        end else begin
            if (push) wr_ptr <= wr_ptr + 1'b1;
            if (pop)  rd_ptr <= rd_ptr + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (push) mem[wr_ptr] <= din;
    end

    assign dout  = mem[rd_ptr];
    assign level = wr_ptr;
    assign empty = (rd_ptr == wr_ptr);

    // R5
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> wr_ptr != AW'(DEPTH - 1));
    // R3
    no_underrun_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty);
endmodule

// File: rtl/nl_pkt_tx.sv
module nl_pkt_tx #(
    parameter int CLK_HZ  = 100_000_000,
    parameter int BAUD    = 115_200,
    parameter int MAX_PKT = 256
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_valid,
    input  logic [7:0] wr_data,
    output logic       wr_ready,
    input  logic       pkt_end,
    output logic       txd,
    output logic       busy,
    output logic       overflow
);
    import nlt_pkg::*;

    localparam int CPB = CLK_HZ / BAUD;
    localparam int AW  = $clog2(MAX_PKT);
    localparam logic [AW-1:0] MAX_PAY = AW'(MAX_PKT - 1);

    tx_state_e     state, state_nx;
    logic          is_term;
    logic          accept, push, pop, clr, load, set_term;
    logic [7:0]    buf_q, ser_data;
    logic [AW-1:0] level;
    logic          empty, ser_active, ser_done;

    nlt_buf #(.DEPTH(MAX_PKT)) u_buf (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (clr),
        .push (push),
        .din  (wr_data),
        .pop  (pop),
        .dout (buf_q),
        .level(level),
        .empty(empty)
    );

    nlt_ser #(.CPB(CPB)) u_ser (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (load),
        .data  (ser_data),
        .txd   (txd),
        .active(ser_active),
        .done  (ser_done)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) state <= S_FILL;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        wr_ready = 1'b0;
        busy     = 1'b1;
        load     = 1'b0;
        pop      = 1'b0;
        clr      = 1'b0;
        set_term = 1'b0;
        ser_data = buf_q;
        unique case (state)
            S_FILL: begin
                wr_ready = 1'b1;
                busy     = 1'b0;
                if (pkt_end) state_nx = S_NEXT;
            end
            S_NEXT: begin
                load     = 1'b1;
                state_nx = S_SHIFT;
                if (empty) begin
                    ser_data = TERM_CHAR;
                    set_term = 1'b1;
                end else begin
                    pop = 1'b1;
                end
            end
            S_SHIFT: begin
                if (ser_done) begin
                    if (is_term) begin
                        state_nx = S_FILL;
                        clr      = 1'b1;
                    end else begin
                        state_nx = S_NEXT;
                    end
                end
            end
            default: state_nx = S_FILL;
        endcase
    end

    assign accept = wr_valid && wr_ready;
    assign push   = accept && (level < MAX_PAY);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            is_term  <= 1'b0;
            overflow <= 1'b0;
        end else begin
            if (set_term) is_term <= 1'b1;
            else if (clr) is_term <= 1'b0;
            if (accept && level == MAX_PAY) overflow <= 1'b1;
        end
    end

    // R6
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        overflow |=> overflow);
    // R2
    txd_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> txd);
    // R8
    busy_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> txd && !ser_active);
    // R7
    no_push_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !push);
endmodule

// File: tb/sim_nl_pkt_tx.sv
module sim_nl_pkt_tx;
    localparam int TB_CPB = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_valid = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       pkt_end = 1'b0;
    logic       wr_ready, txd, busy, overflow;

    int nchk = 0;
    int nerr = 0;
    logic [7:0] exp_q[$];

    always #2 clk = ~clk;

    nl_pkt_tx #(.CLK_HZ(TB_CPB * 115_200), .BAUD(115_200), .MAX_PKT(256)) u0 (
        .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_data(wr_data),
        .wr_ready(wr_ready), .pkt_end(pkt_end), .txd(txd), .busy(busy),
        .overflow(overflow)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr_byte(input logic [7:0] b, input bit with_end, input bit expect_kept);
        wr_valid = 1'b1;
        wr_data  = b;
        pkt_end  = with_end;
        if (expect_kept) exp_q.push_back(b);
        @(negedge clk);
        wr_valid = 1'b0;
        pkt_end  = 1'b0;
    endtask

    task automatic end_pkt();
        exp_q.push_back(8'h0A);
        pkt_end = 1'b1;
        @(negedge clk);
        pkt_end = 1'b0;
    endtask

    task automatic wait_idle(input string req);
        int n = 0;
        while (busy && n < 40000) begin
            @(negedge clk);
            n++;
        end
        check(!busy && txd, req, {busy, txd}, 2'b01);
        check(exp_q.size() == 0, req, exp_q.size(), 0);
    endtask

    // monitor: decodes the line and compares against the scoreboard
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && txd === 1'b0) begin
                logic [7:0] got;
                @(negedge clk);
                check(txd == 1'b0, "R2 start", txd, 0);
                for (int i = 0; i < 8; i++) begin
                    repeat (TB_CPB) @(negedge clk);
                    got[i] = txd;
                end
                repeat (TB_CPB) @(negedge clk);
                check(txd == 1'b1, "R2 stop", txd, 1);
                if (exp_q.size() == 0) begin
                    check(1'b0, "R3 unexpected byte", got, 0);
                end else begin
                    logic [7:0] e;
                    e = exp_q.pop_front();
                    check(got == e, "R3 byte order", got, e);
                end
            end
        end
    end

    initial begin
        repeat (150_000) @(posedge clk);
        nerr++;
        nchk++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("  Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(txd && !busy && wr_ready && !overflow, "R1",
              {txd, busy, wr_ready, overflow}, 4'b1010);

        // R3: short text packet
        wr_byte(8'h41, 0, 1);
        wr_byte(8'h42, 0, 1);
        wr_byte(8'h43, 0, 1);
        check(!busy, "R8 before end", busy, 0);
        end_pkt();
        // R8: busy the cycle after end of packet
        check(busy && !wr_ready, "R8 rise", {busy, wr_ready}, 2'b10);
        // R7: writes and end pulses during transmission are ignored
        repeat (5) begin
            wr_valid = 1'b1;
            wr_data  = 8'hEE;
            pkt_end  = 1'b1;
            @(negedge clk);
            check(!wr_ready, "R7", wr_ready, 0);
        end
        wr_valid = 1'b0;
        pkt_end  = 1'b0;
        wait_idle("R8 fall");

        // R4: lone newline
        end_pkt();
        wait_idle("R4");

        // R3: longer incrementing pattern
        for (int i = 0; i < 10; i++) wr_byte(8'(8'hF0 + i * 3), 0, 1);
        end_pkt();
        wait_idle("R3");

        // R9: write together with end of packet
        wr_byte(8'h11, 0, 1);
        wr_byte(8'h22, 0, 1);
        exp_q.push_back(8'h33);
        exp_q.push_back(8'h0A);
        wr_byte(8'h33, 1, 0);
        check(busy, "R9 busy", busy, 1);
        wait_idle("R9");

        // R5: fill to the limit, then one extra write dropped
        for (int i = 0; i < 255; i++) wr_byte(8'(i), 0, 1);
        check(!overflow && wr_ready, "R5 at limit", {overflow, wr_ready}, 2'b01);
        wr_byte(8'hA5, 0, 0);
        check(overflow, "R5 overflow", overflow, 1);
        // collision of a dropped write with end of packet
        exp_q.push_back(8'h0A);
        wr_byte(8'h5C, 1, 0);
        wait_idle("R5");
        // R6: flag survives the packet and a new one
        check(overflow, "R6", overflow, 1);
        end_pkt();
        wait_idle("R6 next");
        check(overflow, "R6 after", overflow, 1);

        $display("  Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end
endmodule